// File: doc/BRIEF.md
# Cascadable Serial Command Port

This block is a serial slave port that receives fixed 24-bit command frames. A frame is bracketed by an active-low frame strobe (`sync_n`). Bits arrive on `sdin` and are captured on falling edges of the serial clock `sclk`. Every frame also passes out through `sdo`, delayed by one frame length. Identical ports can therefore be cascaded: each `sdo` feeds the next `sdin`, and N ports are loaded with 24×N clocks under one strobe. When the strobe returns high, the last 24 bits held in the port are committed. They come out on a one-cycle write port as an 8-bit address and a 16-bit value, and two control bits inside the port are updated if the frame addresses them.

A bypass mode connects `sdin` straight to `sdo` with no frame delay. It shortens the chain for devices further down and makes the port deaf to every frame. Once bypass is entered, only the hardware reset leaves it. A second control bit lets `sdo` be released, so that a pad can put it in high impedance. The serial pins are sampled with the system clock `clk`, and the pins are assumed to be synchronous to it already.

Top module: `chain_serial_port`

## Requirements
- R1: A frame whose falling-edge count is a non-zero multiple of 24 produces, one `clk` after the strobe rises, exactly one single-cycle `wr_en` pulse. The write carries the last 24 bits received, first bit received as bit 23, with `wr_addr` = bits 23:16 and `wr_data` = bits 15:0.
- R2: `sdin` is taken only on `sclk` falling edges while `sync_n` is low. `sclk` activity while `sync_n` is high changes neither `sdo` nor the write port.
- R3: In normal mode `sdo` changes only on `sclk` rising edges inside a frame, and it repeats the bit taken 24 falling edges earlier. Three cascaded ports are therefore loaded with one 72-clock frame, and the first word sent lands in the last port.
- R4: A frame whose falling-edge count is not a multiple of 24 is dropped with no write, and `frame_err` goes high. `frame_err` returns low at the next strobe falling edge.
- R5: Control bit 0 at address 0x03 releases `sdo` when it is 1 (`sdo_oe` = 0) and drives `sdo` when it is 0 (`sdo_oe` = 1).
- R6: Control bit 0 at address 0x02 set to 1 selects bypass, in which `sdo` equals `sdin` combinationally, with no clock delay.
- R7: In bypass the port issues no write, updates no control bit and never raises `frame_err`. Bypass persists through any frame.
- R8: Hardware reset (`rst_n` low) selects normal mode, sets the release bit (`sdo_oe` = 0), drives `sdo` low and clears `wr_en` and `frame_err`.
- R9: A strobe pulse with no `sclk` falling edge produces neither a write nor `frame_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the serial pins |
| rst_n | input | 1 | Active-low hardware reset; the only exit from bypass |
| sclk | input | 1 | Serial clock |
| sync_n | input | 1 | Active-low frame strobe |
| sdin | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out toward the next port |
| sdo_oe | output | 1 | High when `sdo` is to be driven; low means high impedance |
| wr_en | output | 1 | One-cycle write strobe for a committed frame |
| wr_addr | output | 8 | Register address of the committed frame |
| wr_data | output | 16 | Data value of the committed frame |
| frame_err | output | 1 | Last frame was dropped for a bad bit count |

## Verification
Three ports are cascaded. The chain first receives 24-, 48- and 72-bit frames that enable the outputs one port at a time. These frames show whether each port keeps only the last 24 bits of a longer frame. A 72-bit frame of three distinct words then shows that the words land in reverse order along the chain. A 30-bit frame, a strobe with no clocks and clocks with no strobe tell a dropped frame apart from an empty or ignored one. With the first two ports in bypass, a 24-bit frame must reach the last port directly, and those two ports must stay deaf until a hardware reset returns them to normal mode.

// File: rtl/chain_spi_pkg.sv
package chain_spi_pkg;
    localparam int FRAME_BITS = 24;
    localparam int ADDR_BITS  = 8;
    localparam int DATA_BITS  = 16;
    localparam logic [7:0] MODE_REG_ADDR = 8'h02;
    localparam logic [7:0] OUT_REG_ADDR  = 8'h03;
endpackage

// File: rtl/cs_pin_sampler.sv
module cs_pin_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic sync_n,
    output logic sclk_fall,
    output logic sclk_rise,
    output logic frame_start,
    output logic frame_end,
    output logic in_frame
);
    typedef struct packed {
        logic sclk;
        logic sync;
    } pin_st_t;

    pin_st_t st_d, st_q;

    always_comb begin
        st_d.sclk = sclk;
        st_d.sync = sync_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sclk <= 1'b0;
            st_q.sync <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sclk_fall   = st_q.sclk & ~sclk;
    assign sclk_rise   = ~st_q.sclk & sclk;
    assign frame_start = st_q.sync & ~sync_n;
    assign frame_end   = ~st_q.sync & sync_n;
    assign in_frame    = ~sync_n;
endmodule

// File: rtl/cs_shift_path.sv
module cs_shift_path #(
    parameter int FRAME_W = chain_spi_pkg::FRAME_BITS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               active,
    input  logic               in_frame,
    input  logic               sclk_fall,
    input  logic               sclk_rise,
    input  logic               frame_start,
    input  logic               sdin,
    output logic [FRAME_W-1:0] frame,
    output logic               sdo_q,
    output logic               count_zero,
    output logic               seen
);
    localparam int CNT_W = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_W - 1);

    typedef struct packed {
        logic [FRAME_W-1:0] sr;
        logic [CNT_W-1:0]   cnt;
        logic               seen;
        logic               sdo;
    } shift_st_t;

    shift_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (frame_start) begin
            st_d.cnt  = '0;
            st_d.seen = 1'b0;
        end else if (active && in_frame) begin
            if (sclk_fall) begin
                st_d.sr   = {st_q.sr[FRAME_W-2:0], sdin};
                st_d.cnt  = (st_q.cnt == CNT_LAST) ? '0 : st_q.cnt + 1'b1;
                st_d.seen = 1'b1;
            end
            if (sclk_rise) begin
                st_d.sdo = st_q.sr[FRAME_W-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign frame      = st_q.sr;
    assign sdo_q      = st_q.sdo;
    assign count_zero = (st_q.cnt == '0);
    assign seen       = st_q.seen;

    // R2: nothing is shifted outside a frame
    a_r2_hold_outside_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !in_frame |=> $stable(st_q.sr));
    // R3: serial output moves only after a rising serial clock
    a_r3_sdo_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.sdo) |-> $past(sclk_rise));
    // R7: a bypassed port keeps its shift state
    a_r7_bypass_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !frame_start) |=> ($stable(st_q.sr) && $stable(st_q.sdo)));
endmodule

// File: rtl/cs_ctrl_regs.sv
module cs_ctrl_regs #(
    parameter int FRAME_W = chain_spi_pkg::FRAME_BITS,
    parameter int ADDR_W  = chain_spi_pkg::ADDR_BITS,
    parameter int DATA_W  = chain_spi_pkg::DATA_BITS,
    parameter logic [ADDR_W-1:0] MODE_ADDR = ADDR_W'(chain_spi_pkg::MODE_REG_ADDR),
    parameter logic [ADDR_W-1:0] OUT_ADDR  = ADDR_W'(chain_spi_pkg::OUT_REG_ADDR)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_start,
    input  logic               frame_end,
    input  logic               count_zero,
    input  logic               seen,
    input  logic [FRAME_W-1:0] frame,
    output logic               bypass,
    output logic               sdo_release,
    output logic               wr_en,
    output logic [ADDR_W-1:0]  wr_addr,
    output logic [DATA_W-1:0]  wr_data,
    output logic               frame_err
);
    typedef struct packed {
        logic              bypass;
        logic              release_sdo;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              err;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;
    logic [ADDR_W-1:0] f_addr;
    logic [DATA_W-1:0] f_data;
    logic              commit;

    assign f_addr = frame[FRAME_W-1 -: ADDR_W];
    assign f_data = frame[DATA_W-1:0];
    assign commit = frame_end && !st_q.bypass && seen;

    always_comb begin
        st_d    = st_q;
        st_d.wr = 1'b0;
        if (frame_start) begin
            st_d.err = 1'b0;
        end
        if (commit) begin
            if (count_zero) begin
                st_d.wr   = 1'b1;
                st_d.addr = f_addr;
                st_d.data = f_data;
                if (f_addr == MODE_ADDR) st_d.bypass      = f_data[0];
                if (f_addr == OUT_ADDR)  st_d.release_sdo = f_data[0];
            end else begin
                st_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q             <= '0;
            st_q.release_sdo <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign bypass      = st_q.bypass;
    assign sdo_release = st_q.release_sdo;
    assign wr_en       = st_q.wr;
    assign wr_addr     = st_q.addr;
    assign wr_data     = st_q.data;
    assign frame_err   = st_q.err;

    // R7: only reset leaves bypass
    a_r7_bypass_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.bypass |=> st_q.bypass);
    // R7: no write once bypassed
    a_r7_no_write_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.bypass |=> !st_q.wr);
    // R1: write strobe lasts one cycle
    a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.wr |=> !st_q.wr);
    // R4: a dropped frame never writes
    a_r4_err_excludes_write: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.err && st_q.wr));
endmodule

// File: rtl/chain_serial_port.sv
module chain_serial_port #(
    parameter int FRAME_W = chain_spi_pkg::FRAME_BITS,
    parameter int ADDR_W  = chain_spi_pkg::ADDR_BITS,
    parameter int DATA_W  = chain_spi_pkg::DATA_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              sync_n,
    input  logic              sdin,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              frame_err
);
    logic sclk_fall, sclk_rise, frame_start, frame_end, in_frame;
    logic [FRAME_W-1:0] frame;
    logic sdo_q, count_zero, seen, bypass, sdo_release;

    cs_pin_sampler u_pins (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sync_n(sync_n),
        .sclk_fall(sclk_fall), .sclk_rise(sclk_rise),
        .frame_start(frame_start), .frame_end(frame_end), .in_frame(in_frame)
    );

    cs_shift_path #(.FRAME_W(FRAME_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .active(!bypass), .in_frame(in_frame),
        .sclk_fall(sclk_fall), .sclk_rise(sclk_rise), .frame_start(frame_start),
        .sdin(sdin), .frame(frame), .sdo_q(sdo_q),
        .count_zero(count_zero), .seen(seen)
    );

    cs_ctrl_regs #(.FRAME_W(FRAME_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_end(frame_end),
        .count_zero(count_zero), .seen(seen), .frame(frame),
        .bypass(bypass), .sdo_release(sdo_release), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .frame_err(frame_err)
    );

    assign sdo    = bypass ? sdin : sdo_q;
    assign sdo_oe = !sdo_release;
endmodule

// File: tb/tb_chain_serial_port.sv
`timescale 1ns/1ps
module tb_chain_serial_port;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_head = 1'b0, rst_mid = 1'b0, rst_a = 1'b0;
    logic sclk = 1'b0, sync_n = 1'b1, sdin = 1'b0;

    logic head_sdo, head_oe, head_wr, head_err;
    logic mid_sdo, mid_oe, mid_wr, mid_err;
    logic a_sdo, a_oe, a_wr, a_err;
    logic [7:0]  head_addr, mid_addr, a_addr;
    logic [15:0] head_data, mid_data, a_data;
    logic head_link, mid_link;

    assign head_link = head_oe ? head_sdo : 1'b0;
    assign mid_link  = mid_oe ? mid_sdo : 1'b0;

    chain_serial_port head (.clk(clk), .rst_n(rst_head), .sclk(sclk), .sync_n(sync_n),
        .sdin(sdin), .sdo(head_sdo), .sdo_oe(head_oe), .wr_en(head_wr),
        .wr_addr(head_addr), .wr_data(head_data), .frame_err(head_err));
    chain_serial_port mid (.clk(clk), .rst_n(rst_mid), .sclk(sclk), .sync_n(sync_n),
        .sdin(head_link), .sdo(mid_sdo), .sdo_oe(mid_oe), .wr_en(mid_wr),
        .wr_addr(mid_addr), .wr_data(mid_data), .frame_err(mid_err));
    chain_serial_port dut (.clk(clk), .rst_n(rst_a), .sclk(sclk), .sync_n(sync_n),
        .sdin(mid_link), .sdo(a_sdo), .sdo_oe(a_oe), .wr_en(a_wr),
        .wr_addr(a_addr), .wr_data(a_data), .frame_err(a_err));

    int tests = 0, fails = 0;
    int head_cnt = 0, mid_cnt = 0;
    logic [23:0] head_last = '0, mid_last = '0;
    logic [23:0] exp_q[$];
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // scoreboard monitor for the last port in the chain
    always @(negedge clk) begin
        if (a_wr) begin
            tests++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R1 unexpected write actual=%0h expected=none", {a_addr, a_data});
            end else begin
                logic [23:0] e;
                e = exp_q.pop_front();
                if ({a_addr, a_data} !== e) begin
                    fails++;
                    $display("FAIL R1 write word actual=%0h expected=%0h", {a_addr, a_data}, e);
                end
            end
        end
        if (head_wr) begin head_cnt++; head_last <= {head_addr, head_data}; end
        if (mid_wr)  begin mid_cnt++;  mid_last  <= {mid_addr, mid_data};  end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic frame(input int n, input logic [71:0] bits);
        sync_n = 1'b0;
        wait_n(3);
        for (int i = 0; i < n; i++) begin
            sdin = bits[n-1-i];
            sclk = 1'b1;
            wait_n(3);
            sclk = 1'b0;
            wait_n(3);
        end
        sync_n = 1'b1;
        sdin = 1'b0;
        wait_n(6);
    endtask

    initial begin
        int hc;
        int mc;
        logic prev;
        wait_n(5);
        rst_head = 1'b1; rst_mid = 1'b1; rst_a = 1'b1;
        wait_n(2);
        // R8 reset state
        chk(a_oe == 1'b0 && head_oe == 1'b0, "R8 sdo released after reset", {head_oe, a_oe}, 0);
        chk(head_err == 1'b0 && head_sdo == 1'b0, "R8 err and sdo low", {head_err, head_sdo}, 0);

        // enable outputs one port at a time
        exp_q.push_back(24'h000000);
        frame(24, 72'h030000);
        chk(head_last == 24'h030000 && head_cnt == 1, "R1 head write", head_last, 24'h030000);
        chk(head_oe == 1'b1, "R5 head sdo enabled", head_oe, 1);
        exp_q.push_back(24'h000000);
        frame(48, {24'h0, 24'h030000, 24'h030000});
        chk(mid_oe == 1'b1 && mid_last == 24'h030000, "R1 mid keeps last 24 of 48", mid_last, 24'h030000);
        exp_q.push_back(24'h030000);
        frame(72, {24'h030000, 24'h030000, 24'h030000});
        chk(a_oe == 1'b1, "R5 last port enabled", a_oe, 1);

        // R3: 72-clock normal load
        exp_q.push_back(24'h41A5C3);
        frame(72, {24'h41A5C3, 24'h421234, 24'h43BEEF});
        chk(mid_last == 24'h421234, "R3 middle word", mid_last, 24'h421234);
        chk(head_last == 24'h43BEEF, "R3 head word", head_last, 24'h43BEEF);

        // R4: bad length
        hc = head_cnt;
        frame(30, 72'h3ABCDE123);
        chk(head_err == 1'b1 && a_err == 1'b1, "R4 err flags", {head_err, a_err}, 2'b11);
        chk(head_cnt == hc, "R4 no write on drop", head_cnt, hc);

        // R9 empty strobe; R4 clear on start
        sync_n = 1'b0; wait_n(4); sync_n = 1'b1; wait_n(6);
        chk(head_err == 1'b0 && a_err == 1'b0, "R4 err cleared / R9 no err", {head_err, a_err}, 0);
        chk(head_cnt == hc, "R9 no write for empty strobe", head_cnt, hc);

        // R2: clocks outside a frame
        prev = head_sdo;
        for (int i = 0; i < 8; i++) begin
            sdin = i[0]; sclk = 1'b1; wait_n(3); sclk = 1'b0; wait_n(3);
        end
        chk(head_sdo == prev && head_cnt == hc, "R2 sdo held with strobe high", head_sdo, prev);

        // enter bypass on head and mid
        exp_q.push_back(24'h201111);
        frame(72, {24'h201111, 24'h020001, 24'h020001});
        chk(head_last == 24'h020001 && mid_last == 24'h020001, "R6 bypass writes", head_last, 24'h020001);

        // R6: combinational pass-through
        sdin = 1'b1; #1;
        chk(mid_sdo == 1'b1, "R6 sdo follows sdin high", mid_sdo, 1);
        sdin = 1'b0; #1;
        chk(mid_sdo == 1'b0, "R6 sdo follows sdin low", mid_sdo, 0);
        wait_n(2);

        // R6/R7: 24 clocks reach the last port
        hc = head_cnt; mc = mid_cnt;
        exp_q.push_back(24'h55BEEF);
        frame(24, 72'h55BEEF);
        chk(head_cnt == hc && mid_cnt == mc, "R7 bypassed ports silent", head_cnt, hc);

        // R7: bad length ignored in bypass
        frame(30, 72'h3ABCDE123);
        chk(head_err == 1'b0 && a_err == 1'b1, "R7 no err in bypass", {head_err, a_err}, 2'b01);
        exp_q.push_back(24'h60ABCD);
        frame(24, 72'h60ABCD);
        chk(head_cnt == hc && mid_cnt == mc, "R7 bypass persists", mid_cnt, mc);

        // R8: hardware reset leaves bypass
        rst_head = 1'b0; rst_mid = 1'b0; wait_n(3); rst_head = 1'b1; rst_mid = 1'b1; wait_n(2);
        chk(head_oe == 1'b0 && mid_oe == 1'b0, "R8 reset releases sdo", {head_oe, mid_oe}, 0);
        exp_q.push_back(24'h000000);
        frame(24, 72'h030000);
        chk(head_cnt == hc + 1 && head_last == 24'h030000, "R8 normal mode after reset", head_last, 24'h030000);

        wait_n(4);
        chk(exp_q.size() == 0, "R1 all expected writes seen", exp_q.size(), 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule